// File: doc/BRIEF.md
# Serial EEPROM Burst Read Master

This block fetches a run of consecutive 16-bit words from a three-wire serial EEPROM that follows the Microwire READ protocol, and delivers them on a simple valid/data stream. A one-cycle start pulse carries a 6-bit first address and a word count. The EEPROM pins sit on a port shared with another agent. The block therefore raises a port request first and waits for a grant. If the grant does not come within a timeout of nominally one second, it gives up and reports an error.

Once granted, the block makes the chip select, serial clock and serial data-out waveforms from the system clock. The phase lengths come from the system clock frequency and the minimum high and low times. For each word, chip select is held for one full serial clock period before the read command is sent. The block then shifts in seventeen bits, so that the device's dummy zero drops off the top of the word. A single idle clock pulse with chip select low separates one word from the next. The address advances by one per word and wraps from 63 to 0. When the last word is finished, every port pin is released to 0 and done pulses.

Top module: `seeprom_burst_reader`

## Requirements
- R1: While reset is asserted, and after it, busy, wordValid, done, error, portReq, eeCs, eeSk and eeDo are all 0.
- R2: A start pulse taken in idle with a nonzero wordCount raises portReq and busy at the next clock edge. eeCs stays low until portGrant is sampled high, and it rises at the clock edge that samples the grant.
- R3: If portGrant is not sampled high within TMO_CYC = (CLK_FREQ_HZ/1e6)*GRANT_TIMEOUT_US cycles, error pulses for one cycle exactly TMO_CYC clock edges after the start was taken. From that cycle on, portReq, eeCs, eeSk, eeDo and busy are 0.
- R4: Each word frame begins with eeCs rising while eeSk is low. eeDo is 0 during the first serial clock period. In the next nine periods eeDo carries 1, 1, 0 (start bit, then READ opcode 10), followed by the six address bits MSB first. eeDo only changes while eeSk is low.
- R5: Phase lengths are HIGH_CYC = ceil(SK_HIGH_NS*CLK_FREQ_HZ/1e9) cycles for eeSk high and LOW_CYC = ceil(SK_LOW_NS*CLK_FREQ_HZ/1e9) cycles for eeSk low inside a frame. The start bit appears on eeDo exactly LOW_CYC+HIGH_CYC cycles after eeCs rises.
- R6: eeSk rises exactly 27 times per frame while eeCs is high. eeDi is sampled in the last low cycle before each of rises 11 to 27. The first of these samples is dropped, and the other sixteen form the word, MSB first.
- R7: wordValid is a one-cycle pulse in the first cycle in which eeCs is low after a frame, with the completed word on wordData.
- R8: After eeCs falls there is exactly one eeSk pulse with eeCs low. eeSk then stays low, and exactly 2*LOW_CYC+HIGH_CYC cycles pass before eeCs rises for the next word or done pulses.
- R9: A burst of N words reads addresses startAddr, startAddr+1, ... up to N words, modulo 64.
- R10: After the last word's trailing idle clock, done pulses for one cycle. In that cycle portReq, eeCs, eeSk, eeDo and busy are already 0.
- R11: A start pulse while busy is ignored: the running burst keeps its address and word count.
- R12: A start with wordCount 0 pulses done at the next clock edge without raising portReq or busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle burst request |
| startAddr | input | ADDR_W (6) | First word address |
| wordCount | input | CNT_W (7) | Number of words to read |
| busy | output | 1 | Burst or arbitration in progress |
| wordValid | output | 1 | One-cycle strobe for wordData |
| wordData | output | DATA_W (16) | Word read from the EEPROM |
| done | output | 1 | One-cycle pulse at burst end |
| error | output | 1 | One-cycle pulse on grant timeout |
| portReq | output | 1 | Shared-port access request |
| portGrant | input | 1 | Shared-port access granted |
| eeCs | output | 1 | EEPROM chip select |
| eeSk | output | 1 | EEPROM serial clock |
| eeDo | output | 1 | Serial data to the EEPROM |
| eeDi | input | 1 | Serial data from the EEPROM |

## Verification
Every result has a fixed distance in clock edges from the stimulus that causes it. portReq follows start by one edge and eeCs follows a sampled grant by one edge. error comes TMO_CYC edges after the start edge. The start bit comes LOW_CYC+HIGH_CYC edges after eeCs rises. wordValid appears on the same edge on which eeCs falls, and the next eeCs rise or done comes 2*LOW_CYC+HIGH_CYC edges after that. The bench stamps each edge with a cycle counter and samples on the falling clock edge, so each check compares stamp differences with these counts. The bench's EEPROM model changes eeDi only after an eeSk rise, so a sample taken one cycle late or early shows up as a wrong word.

// File: rtl/seeprom_rd_pkg.sv
package seeprom_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACQ,
    ST_XFER
  } rd_state_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic startLoad;   // latch start address and count
    logic loadCmd;     // begin a frame: load command shifter, eeDo low
    logic shiftOut;    // put next command bit on eeDo
    logic sampleIn;    // shift eeDi into receive register
    logic wordDone;    // publish word, advance address, count down
    logic clearOut;    // release eeDo
  } rd_strobe_t;

endpackage

// File: rtl/seeprom_rd_ctrl.sv
module seeprom_rd_ctrl
  import seeprom_rd_pkg::*;
#(
  parameter int CLK_FREQ_HZ      = 200_000_000,
  parameter int SK_HIGH_NS       = 750,
  parameter int SK_LOW_NS        = 250,
  parameter int GRANT_TIMEOUT_US = 1_000_000,
  parameter int ADDR_W           = 6,
  parameter int DATA_W           = 16,
  parameter int CNT_W            = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] wordCount,
  input  logic             portGrant,
  input  logic             burstDone,
  output rd_strobe_t       stb,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic             portReq,
  output logic             eeCs,
  output logic             eeSk
);

  localparam longint NS_PER_S = 64'd1_000_000_000;
  localparam int LOW_CYC  = int'((longint'(SK_LOW_NS)  * CLK_FREQ_HZ + NS_PER_S - 1) / NS_PER_S);
  localparam int HIGH_CYC = int'((longint'(SK_HIGH_NS) * CLK_FREQ_HZ + NS_PER_S - 1) / NS_PER_S);
  localparam int PH_MAX   = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int PH_W     = $clog2(PH_MAX + 1);
  localparam longint TMO_CYC = longint'(CLK_FREQ_HZ / 1_000_000) * GRANT_TIMEOUT_US;
  localparam int TMO_W    = $clog2(TMO_CYC + 1);

  // frame slots: 0 select, 1..3 command, then address, then read, trailer, tail
  localparam int READ_FIRST_I = ADDR_W + 4;
  localparam int READ_LAST_I  = READ_FIRST_I + DATA_W;
  localparam int TAIL_I       = READ_LAST_I + 2;
  localparam int SLOT_W       = $clog2(TAIL_I + 1);

  localparam logic [SLOT_W-1:0] READ_FIRST = SLOT_W'(READ_FIRST_I);
  localparam logic [SLOT_W-1:0] READ_LAST  = SLOT_W'(READ_LAST_I);
  localparam logic [SLOT_W-1:0] TAIL_SLOT  = SLOT_W'(TAIL_I);
  localparam logic [PH_W-1:0]   LOW_LD     = PH_W'(LOW_CYC - 1);
  localparam logic [PH_W-1:0]   HIGH_LD    = PH_W'(HIGH_CYC - 1);
  localparam logic [TMO_W-1:0]  TMO_LAST   = TMO_W'(TMO_CYC - 1);

  rd_state_e         state;
  logic [SLOT_W-1:0] slot;
  logic [PH_W-1:0]   phaseCnt;
  logic [TMO_W-1:0]  tmoCnt;
  logic              skHigh;
  logic              phaseEnd;
  logic              tmoHit;

  assign phaseEnd = (phaseCnt == '0);
  assign tmoHit   = (tmoCnt == TMO_LAST);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    stb = '0;
    case (state)
      ST_IDLE: stb.startLoad = start && (wordCount != '0);
      ST_ACQ: begin
        stb.loadCmd  = portGrant;
        stb.clearOut = !portGrant && tmoHit;
      end
      ST_XFER: begin
        if (phaseEnd) begin
          if (!skHigh) begin
            stb.sampleIn = (slot >= READ_FIRST) && (slot <= READ_LAST);
            if (slot == TAIL_SLOT) begin
              stb.loadCmd  = !burstDone;
              stb.clearOut = burstDone;
            end
          end else begin
            stb.shiftOut = (slot < READ_FIRST);
            stb.wordDone = (slot == READ_LAST);
          end
        end
      end
      default: stb = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      slot     <= '0;
      phaseCnt <= '0;
      tmoCnt   <= '0;
      skHigh   <= 1'b0;
      done     <= 1'b0;
      error    <= 1'b0;
      portReq  <= 1'b0;
      eeCs     <= 1'b0;
      eeSk     <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (wordCount == '0) begin
              done <= 1'b1;
            end else begin
              state   <= ST_ACQ;
              portReq <= 1'b1;
              tmoCnt  <= '0;
            end
          end
        end
        ST_ACQ: begin
          if (portGrant) begin
            state    <= ST_XFER;
            eeCs     <= 1'b1;
            slot     <= '0;
            skHigh   <= 1'b0;
            phaseCnt <= LOW_LD;
          end else if (tmoHit) begin
            state   <= ST_IDLE;
            portReq <= 1'b0;
            error   <= 1'b1;
          end else begin
            tmoCnt <= tmoCnt + 1'b1;
          end
        end
        ST_XFER: begin
          if (!phaseEnd) begin
            phaseCnt <= phaseCnt - 1'b1;
          end else if (!skHigh) begin
            if (slot == TAIL_SLOT) begin
              if (burstDone) begin
                state   <= ST_IDLE;
                portReq <= 1'b0;
                done    <= 1'b1;
              end else begin
                slot     <= '0;
                eeCs     <= 1'b1;
                phaseCnt <= LOW_LD;
              end
            end else begin
              skHigh   <= 1'b1;
              eeSk     <= 1'b1;
              phaseCnt <= HIGH_LD;
            end
          end else begin
            skHigh   <= 1'b0;
            eeSk     <= 1'b0;
            slot     <= slot + 1'b1;
            phaseCnt <= LOW_LD;
            if (slot == READ_LAST) eeCs <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/seeprom_rd_datapath.sv
module seeprom_rd_datapath
  import seeprom_rd_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  rd_strobe_t        stb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  wordCount,
  input  logic              eeDi,
  output logic              eeDo,
  output logic              burstDone,
  output logic              wordValid,
  output logic [DATA_W-1:0] wordData
);

  localparam int CMD_W = ADDR_W + 3;
  localparam logic [2:0] READ_CMD = 3'b110;   // start bit, opcode 10

  logic [ADDR_W-1:0] addrReg;
  logic [CNT_W-1:0]  wordsLeft;
  logic [CMD_W-1:0]  cmdSr;
  logic [DATA_W-1:0] rxSr;

  assign burstDone = (wordsLeft == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg   <= '0;
      wordsLeft <= '0;
      cmdSr     <= '0;
      rxSr      <= '0;
      eeDo      <= 1'b0;
      wordValid <= 1'b0;
      wordData  <= '0;
    end else begin
      wordValid <= stb.wordDone;
      if (stb.startLoad) begin
        addrReg   <= startAddr;
        wordsLeft <= wordCount;
      end
      if (stb.wordDone) begin
        addrReg   <= addrReg + 1'b1;
        wordsLeft <= wordsLeft - 1'b1;
        wordData  <= rxSr;
      end
      if (stb.loadCmd) begin
        cmdSr <= {READ_CMD, addrReg};
        eeDo  <= 1'b0;
      end else if (stb.shiftOut) begin
        eeDo  <= cmdSr[CMD_W-1];
        cmdSr <= {cmdSr[CMD_W-2:0], 1'b0};
      end
      if (stb.clearOut) eeDo <= 1'b0;
      // 17 shifts per word: the dummy zero leaves through the top
      if (stb.sampleIn) rxSr <= {rxSr[DATA_W-2:0], eeDi};
    end
  end

endmodule

// File: rtl/seeprom_burst_reader.sv
module seeprom_burst_reader
  import seeprom_rd_pkg::*;
#(
  parameter int CLK_FREQ_HZ      = 200_000_000,
  parameter int SK_HIGH_NS       = 750,
  parameter int SK_LOW_NS        = 250,
  parameter int GRANT_TIMEOUT_US = 1_000_000,
  parameter int ADDR_W           = 6,
  parameter int DATA_W           = 16,
  parameter int CNT_W            = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  wordCount,
  output logic              busy,
  output logic              wordValid,
  output logic [DATA_W-1:0] wordData,
  output logic              done,
  output logic              error,
  output logic              portReq,
  input  logic              portGrant,
  output logic              eeCs,
  output logic              eeSk,
  output logic              eeDo,
  input  logic              eeDi
);

  rd_strobe_t stb;
  logic       burstDone;

  seeprom_rd_ctrl #(
    .CLK_FREQ_HZ(CLK_FREQ_HZ), .SK_HIGH_NS(SK_HIGH_NS), .SK_LOW_NS(SK_LOW_NS),
    .GRANT_TIMEOUT_US(GRANT_TIMEOUT_US), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .wordCount(wordCount),
    .portGrant(portGrant), .burstDone(burstDone), .stb(stb), .busy(busy),
    .done(done), .error(error), .portReq(portReq), .eeCs(eeCs), .eeSk(eeSk)
  );

  seeprom_rd_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .startAddr(startAddr), .wordCount(wordCount),
    .eeDi(eeDi), .eeDo(eeDo), .burstDone(burstDone), .wordValid(wordValid),
    .wordData(wordData)
  );

endmodule

// File: rtl/seeprom_burst_reader_chk.sv
module seeprom_burst_reader_chk (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic wordValid,
  input logic done,
  input logic error,
  input logic portReq,
  input logic eeCs,
  input logic eeSk,
  input logic eeDo
);

  AST_PINS_NEED_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (eeCs || eeSk || eeDo) |-> portReq);                                   // R10

  AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    portReq |-> busy);                                                      // R2

  AST_DO_STABLE_SK_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    eeSk |-> $stable(eeDo));                                                // R4

  AST_CS_RISE_SK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eeCs) |-> !eeSk);                                                 // R4

  AST_VALID_CS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> !eeCs);                                                   // R7

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);                                              // R7

  AST_ERR_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    error |-> (!portReq && !eeCs && !eeSk && !eeDo && !busy));             // R3

  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!portReq && !eeCs && !eeSk && !eeDo && !busy));              // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);                                                        // R10

endmodule

bind seeprom_burst_reader seeprom_burst_reader_chk chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .wordValid(wordValid), .done(done),
  .error(error), .portReq(portReq), .eeCs(eeCs), .eeSk(eeSk), .eeDo(eeDo)
);

// File: tb/seeprom_burst_reader_tb_top.sv
`timescale 1ns/1ps
module seeprom_burst_reader_tb_top;

  localparam int F_HZ     = 200_000_000;
  localparam int HIGH_NS  = 750;
  localparam int LOW_NS   = 250;
  localparam int TMO_US   = 10;
  localparam int LOW_CYC  = (LOW_NS * (F_HZ / 1_000_000) + 999) / 1000;
  localparam int HIGH_CYC = (HIGH_NS * (F_HZ / 1_000_000) + 999) / 1000;
  localparam int TMO_CYC  = (F_HZ / 1_000_000) * TMO_US;
  localparam int NVEC     = 6;
  // {addr, count, grant delay (FF = never), start-while-busy}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'd5,  8'd3, 8'd0,  8'd0},
    {8'd62, 8'd3, 8'd37, 8'd0},
    {8'd0,  8'd1, 8'd5,  8'd0},
    {8'd33, 8'd0, 8'd0,  8'd0},
    {8'd7,  8'd2, 8'hFF, 8'd0},
    {8'd10, 8'd2, 8'd3,  8'd1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  startAddr = '0;
  logic [6:0]  wordCount = '0;
  logic        busy, wordValid, done, error, portReq, eeCs, eeSk, eeDo;
  logic [15:0] wordData;
  logic        portGrant = 1'b0;
  logic        eeDi = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int curStart = 0;
  int nWords = 0;
  int nCmd = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  seeprom_burst_reader #(.GRANT_TIMEOUT_US(TMO_US)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr), .wordCount(wordCount),
    .busy(busy), .wordValid(wordValid), .wordData(wordData), .done(done), .error(error),
    .portReq(portReq), .portGrant(portGrant), .eeCs(eeCs), .eeSk(eeSk), .eeDo(eeDo),
    .eeDi(eeDi)
  );

  function automatic logic [15:0] romWord(input int a);
    return 16'((a * 40503) ^ 16'h8421);
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkPinsIdle(input string req);
    check(req, "portReq", portReq, 0);
    check(req, "eeCs", eeCs, 0);
    check(req, "eeSk", eeSk, 0);
    check(req, "eeDo", eeDo, 0);
    check(req, "busy", busy, 0);
  endtask

  // EEPROM model: decodes command, answers dummy zero then 16 bits
  initial begin
    int mPhase = 0, mCnt = 0, mBit = 0;
    logic [1:0]  mOp = '0;
    logic [5:0]  mAddr = '0;
    logic [15:0] mWord = '0;
    forever begin
      @(posedge eeSk or negedge eeCs);
      if (!eeCs) begin
        mPhase = 0;
        eeDi = 1'b0;
        continue;
      end
      case (mPhase)
        0: if (eeDo) begin mPhase = 1; mCnt = 0; mOp = '0; end
        1: begin
          mOp = {mOp[0], eeDo}; mCnt++;
          if (mCnt == 2) begin mPhase = 2; mCnt = 0; mAddr = '0; end
        end
        2: begin
          mAddr = {mAddr[4:0], eeDo}; mCnt++;
          if (mCnt == 6) begin
            check("R4", "opcode", mOp, 2);
            check("R9", "address", mAddr, (curStart + nCmd) % 64);
            nCmd++;
            mWord = romWord(int'(mAddr));
            mBit = 15;
            mPhase = 3;
            #1 eeDi = 1'b0;
          end
        end
        default: if (mBit >= 0) begin #1 eeDi = mWord[mBit]; mBit--; end
      endcase
    end
  end

  // waveform monitor, sampled on falling clock edges
  initial begin
    logic prevSk = 0, prevCs = 0, prevDo = 0;
    bit lowTrack = 0, seenStart = 0, inTrail = 0;
    int lowRun = 0, highRun = 0, csRiseCyc = 0, csFallCyc = 0, rises = 0, trailRises = 0;
    forever begin
      @(negedge clk);
      if (!rstN) begin
        lowTrack = 0; inTrail = 0; seenStart = 1; rises = 0;
      end else begin
        if (eeSk && !prevSk) begin
          highRun = 1;
          if (lowTrack) check("R5", "sk low cycles", lowRun, LOW_CYC);
          lowTrack = 0;
          if (eeCs) rises++;
          else if (inTrail) trailRises++;
        end else if (eeSk) highRun++;
        if (!eeSk && prevSk) begin
          check("R5", "sk high cycles", highRun, HIGH_CYC);
          lowTrack = eeCs;
          lowRun = 1;
        end else if (!eeSk) lowRun++;
        if (eeDo != prevDo) check("R4", "eeDo changes with sk low", eeSk, 0);
        if (eeCs && !prevCs) begin
          check("R4", "sk low at cs rise", eeSk, 0);
          if (inTrail) begin
            check("R8", "trailer cycles", cyc - csFallCyc, 2 * LOW_CYC + HIGH_CYC);
            check("R8", "trailer pulses", trailRises, 1);
            inTrail = 0;
          end
          csRiseCyc = cyc; seenStart = 0; rises = 0;
        end
        if (eeDo && !prevDo && eeCs && !seenStart) begin
          check("R5", "start bit delay", cyc - csRiseCyc, LOW_CYC + HIGH_CYC);
          seenStart = 1;
        end
        if (!eeCs && prevCs) begin
          check("R6", "sk rises per frame", rises, 27);
          check("R7", "valid at cs fall", wordValid, 1);
          inTrail = 1; csFallCyc = cyc; trailRises = 0;
        end
        if (done && inTrail) begin
          check("R8", "tail cycles before done", cyc - csFallCyc, 2 * LOW_CYC + HIGH_CYC);
          check("R8", "tail pulses", trailRises, 1);
          check("R8", "sk low at done", eeSk, 0);
          inTrail = 0;
        end
        if (wordValid) begin
          check("R7", "wordData", wordData, romWord((curStart + nWords) % 64));
          nWords++;
        end
      end
      prevSk = eeSk; prevCs = eeCs; prevDo = eeDo;
    end
  end

  task automatic runBurst(input int addr, input int cnt, input int gDelay, input bit midStart);
    int t0;
    curStart = addr; nWords = 0; nCmd = 0;
    @(negedge clk);
    start = 1'b1; startAddr = 6'(addr); wordCount = 7'(cnt);
    @(negedge clk);
    start = 1'b0;
    t0 = cyc;
    if (cnt == 0) begin
      check("R12", "done after zero count", done, 1);
      check("R12", "no request", portReq, 0);
      check("R12", "not busy", busy, 0);
      @(negedge clk);
      check("R12", "done single cycle", done, 0);
      return;
    end
    check("R2", "request after start", portReq, 1);
    check("R2", "busy after start", busy, 1);
    if (gDelay < 255) begin
      repeat (gDelay) @(negedge clk);
      check("R2", "cs low before grant", eeCs, 0);
      portGrant = 1'b1;
      @(negedge clk);
      check("R2", "cs after grant", eeCs, 1);
      if (midStart) begin
        repeat (500) @(negedge clk);
        start = 1'b1; startAddr = 6'd40; wordCount = 7'd5;
        @(negedge clk);
        start = 1'b0;
      end
      while (!done) @(negedge clk);
      check("R10", "done pins", portReq | eeCs | eeSk | eeDo, 0);
      check("R10", "busy at done", busy, 0);
      if (midStart) check("R11", "words despite restart", nWords, cnt);
      else check("R9", "word count", nWords, cnt);
      check("R9", "commands sent", nCmd, cnt);
      @(negedge clk);
      check("R10", "done single cycle", done, 0);
      portGrant = 1'b0;
    end else begin
      while (!error) @(negedge clk);
      check("R3", "timeout cycles", cyc - t0, TMO_CYC);
      checkPinsIdle("R3");
      check("R3", "no words", nWords, 0);
      @(negedge clk);
      check("R3", "error single cycle", error, 0);
    end
  endtask

  bit finished = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkPinsIdle("R1");
    check("R1", "valid in reset", wordValid | done | error, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkPinsIdle("R1");
    for (int i = 0; i < NVEC; i++) begin
      runBurst(int'(VEC[i][31:24]), int'(VEC[i][23:16]), int'(VEC[i][15:8]), VEC[i][0]);
      repeat (10) @(negedge clk);
    end
    // reset in the middle of a burst
    curStart = 20; nWords = 0; nCmd = 0;
    start = 1'b1; startAddr = 6'd20; wordCount = 7'd4; portGrant = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (1000) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkPinsIdle("R1");
    check("R1", "strobes in reset", wordValid | done | error, 0);
    portGrant = 1'b0;
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    checkPinsIdle("R1");
    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule